// File: doc/BRIEF.md
# Tunnelled PHY Register Access Sequencer

This block takes single register requests from a host (read or write of a PHY number and register number) and carries each one out as a series of plain Clause 22 management accesses to a switch at one fixed management address. The switch exposes only two registers there: a command register with a busy flag and a data register. For every host request the sequencer waits for the busy flag to drop, writes the data word when the request is a write, issues a command word that encodes the target PHY and register, waits for busy to drop again and, for reads, fetches the data register.

Each wait is bounded. A read whose wait runs out is abandoned and returns zero with a timeout flag. A write whose wait runs out still completes its remaining steps and reports the timeout. Host reads of the basic status register never go out on the bus. They are answered locally, so that only the switch's own address appears to hold a PHY.

The downstream side is a simple request/acknowledge port toward an existing serial management master. The host side is a valid/ready request with a one-cycle completion pulse, and one request is in flight at a time.

Top module: `smi_tunnel_seq`

## Requirements
- R1: Every downstream access uses management address 0x10. Command accesses use register 0 and data accesses use register 1.
- R2: An issued command word has bit 15 (busy) and bit 12 (Clause 22 select) set, and exactly one of bit 11 (read) or bit 10 (write). The target PHY is in bits 9:5 and the target register in bits 4:0.
- R3: A read request runs as: wait for busy clear, write the command word, wait for busy clear, read the data register. The value read is returned on host_rdata.
- R4: A write request runs as: wait for busy clear, write host_wdata to the data register, write the command word, wait for busy clear. host_rdata is 0 on completion.
- R5: A wait reads the command register repeatedly and stops at the first read whose bit 15 is 0. A wait that sees N busy reads therefore takes N+1 reads.
- R6: A wait gives up after 10000 consecutive busy reads. On a read request this ends the sequence at once, with host_rdata 0 and host_timeout 1, and makes no further bus access.
- R7: On a write request an expired wait does not stop the sequence. All remaining steps run, and completion reports host_timeout 1.
- R8: A host read of register 1 at PHY 0x10 completes one cycle after acceptance with value 0x0124 (bit 8, bit 5 and bit 2 set) and makes no bus access.
- R9: A host read of register 1 at any other PHY completes with value 0 and makes no bus access. A host write to register 1 is tunnelled like any other write.
- R10: host_ready is high only while no request is in progress. host_done is a single-cycle pulse.
- R11: After reset host_ready is 1, host_done is 0 and mdio_req is 0.
- R12: A downstream request, with its direction, register and data, is held unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Sequencer idle, request accepted when valid |
| host_rw | input | 1 | 1 = write, 0 = read |
| host_phy | input | 5 | Target PHY number |
| host_reg | input | 5 | Target register number |
| host_wdata | input | 16 | Write value |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read result, valid with host_done |
| host_timeout | output | 1 | A busy wait expired, valid with host_done |
| mdio_req | output | 1 | Downstream access request |
| mdio_rw | output | 1 | 1 = write, 0 = read |
| mdio_addr | output | 5 | Management address |
| mdio_reg | output | 5 | Register at that address |
| mdio_wdata | output | 16 | Downstream write value |
| mdio_ack | input | 1 | Downstream access complete |
| mdio_rdata | input | 16 | Downstream read value, valid with mdio_ack |

## Verification
The checks assume that the host raises host_valid only between completions and keeps its fields steady while it does so. They also assume that the downstream master pulses mdio_ack for exactly one cycle per request and only while mdio_req is high. The bench's bus model answers each request once, one clock after it appears, and then drops the acknowledge for a cycle. The host task presents a request for a single accepted cycle and waits for completion before it issues the next one, so the stimulus never breaks either assumption.

// File: rtl/smi_tunnel_pkg.sv
package smi_tunnel_pkg;

    localparam int DATA_W = 16;
    localparam int FLD_W  = 5;

    // command word bit positions (decoded by the switch)
    localparam int CMD_BUSY_BIT = 15;
    localparam int CMD_C22_BIT  = 12;
    localparam int CMD_RD_BIT   = 11;
    localparam int CMD_WR_BIT   = 10;
    localparam int CMD_PHY_LSB  = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL_PRE,
        S_DATA_WR,
        S_CMD_WR,
        S_POLL_POST,
        S_DATA_RD,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e              st;
        logic                    rw;
        logic [FLD_W-1:0]        phy;
        logic [FLD_W-1:0]        regn;
        logic [DATA_W-1:0]       wdata;
        logic [DATA_W-1:0]       rdata;
        logic                    tout;
    } seq_regs_t;

endpackage

// File: rtl/smi_cmd_pack.sv
module smi_cmd_pack
    import smi_tunnel_pkg::*;
(
    input  logic              rw,
    input  logic [FLD_W-1:0]  phy,
    input  logic [FLD_W-1:0]  regn,
    output logic [DATA_W-1:0] cmd
);
    always_comb begin
        cmd                                   = '0;
        cmd[CMD_BUSY_BIT]                     = 1'b1;
        cmd[CMD_C22_BIT]                      = 1'b1;
        cmd[CMD_RD_BIT]                       = ~rw;
        cmd[CMD_WR_BIT]                       = rw;
        cmd[CMD_PHY_LSB +: FLD_W]             = phy;
        cmd[FLD_W-1:0]                        = regn;
    end
endmodule

// File: rtl/smi_status_mask.sv
module smi_status_mask
    import smi_tunnel_pkg::*;
#(
    parameter logic [FLD_W-1:0]  STATUS_REG = 5'h01,
    parameter logic [FLD_W-1:0]  SW_ADDR    = 5'h10,
    parameter logic [DATA_W-1:0] STATUS_VAL = 16'h0124
) (
    input  logic              rw,
    input  logic [FLD_W-1:0]  phy,
    input  logic [FLD_W-1:0]  regn,
    output logic              hit,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        hit   = ~rw && (regn == STATUS_REG);
        value = (phy == SW_ADDR) ? STATUS_VAL : '0;
    end
endmodule

// File: rtl/smi_poll_limiter.sv
module smi_poll_limiter #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy_seen,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (busy_seen)
            cnt_d = cnt_q + 1'b1;
        expired = busy_seen && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smi_tunnel_seq.sv
module smi_tunnel_seq
    import smi_tunnel_pkg::*;
#(
    parameter logic [FLD_W-1:0]  SW_ADDR    = 5'h10,
    parameter logic [FLD_W-1:0]  CMD_REG    = 5'h00,
    parameter logic [FLD_W-1:0]  DATA_REG   = 5'h01,
    parameter logic [FLD_W-1:0]  STATUS_REG = 5'h01,
    parameter logic [DATA_W-1:0] STATUS_VAL = 16'h0124,
    parameter int                POLL_LIMIT = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_rw,
    input  logic [FLD_W-1:0]  host_phy,
    input  logic [FLD_W-1:0]  host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_timeout,
    output logic              mdio_req,
    output logic              mdio_rw,
    output logic [FLD_W-1:0]  mdio_addr,
    output logic [FLD_W-1:0]  mdio_reg,
    output logic [DATA_W-1:0] mdio_wdata,
    input  logic              mdio_ack,
    input  logic [DATA_W-1:0] mdio_rdata
);
    seq_regs_t q, d;

    logic [DATA_W-1:0] cmd_word;
    logic              stat_hit;
    logic [DATA_W-1:0] stat_val;
    logic              in_poll;
    logic              busy_bit;
    logic              poll_busy;
    logic              poll_expired;

    smi_cmd_pack u_cmd (
        .rw   (q.rw),
        .phy  (q.phy),
        .regn (q.regn),
        .cmd  (cmd_word)
    );

    smi_status_mask #(
        .STATUS_REG (STATUS_REG),
        .SW_ADDR    (SW_ADDR),
        .STATUS_VAL (STATUS_VAL)
    ) u_stat (
        .rw    (host_rw),
        .phy   (host_phy),
        .regn  (host_reg),
        .hit   (stat_hit),
        .value (stat_val)
    );

    smi_poll_limiter #(
        .LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (~in_poll),
        .busy_seen (poll_busy),
        .expired   (poll_expired)
    );

    // downstream access drive, purely from the current step
    always_comb begin
        in_poll    = (q.st == S_POLL_PRE) || (q.st == S_POLL_POST);
        busy_bit   = mdio_rdata[CMD_BUSY_BIT];
        poll_busy  = in_poll && mdio_ack && busy_bit;

        mdio_req   = 1'b0;
        mdio_rw    = 1'b0;
        mdio_addr  = SW_ADDR;
        mdio_reg   = CMD_REG;
        mdio_wdata = '0;
        unique case (q.st)
            S_POLL_PRE, S_POLL_POST: begin
                mdio_req = 1'b1;
            end
            S_DATA_WR: begin
                mdio_req   = 1'b1;
                mdio_rw    = 1'b1;
                mdio_reg   = DATA_REG;
                mdio_wdata = q.wdata;
            end
            S_CMD_WR: begin
                mdio_req   = 1'b1;
                mdio_rw    = 1'b1;
                mdio_wdata = cmd_word;
            end
            S_DATA_RD: begin
                mdio_req = 1'b1;
                mdio_reg = DATA_REG;
            end
            default: ;
        endcase
    end

    // sequencing
    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (host_valid) begin
                    d.rw    = host_rw;
                    d.phy   = host_phy;
                    d.regn  = host_reg;
                    d.wdata = host_wdata;
                    d.tout  = 1'b0;
                    d.rdata = '0;
                    if (stat_hit) begin
                        d.rdata = stat_val;
                        d.st    = S_DONE;
                    end else begin
                        d.st = S_POLL_PRE;
                    end
                end
            end
            S_POLL_PRE: begin
                if (mdio_ack) begin
                    if (!busy_bit) begin
                        d.st = q.rw ? S_DATA_WR : S_CMD_WR;
                    end else if (poll_expired) begin
                        d.tout = 1'b1;
                        d.st   = q.rw ? S_DATA_WR : S_DONE;
                    end
                end
            end
            S_DATA_WR: begin
                if (mdio_ack) d.st = S_CMD_WR;
            end
            S_CMD_WR: begin
                if (mdio_ack) d.st = S_POLL_POST;
            end
            S_POLL_POST: begin
                if (mdio_ack) begin
                    if (!busy_bit) begin
                        d.st = q.rw ? S_DONE : S_DATA_RD;
                    end else if (poll_expired) begin
                        d.tout = 1'b1;
                        d.st   = S_DONE;
                    end
                end
            end
            S_DATA_RD: begin
                if (mdio_ack) begin
                    d.rdata = mdio_rdata;
                    d.st    = S_DONE;
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, rw: 1'b0, phy: '0, regn: '0,
                   wdata: '0, rdata: '0, tout: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign host_ready   = (q.st == S_IDLE);
    assign host_done    = (q.st == S_DONE);
    assign host_rdata   = q.rdata;
    assign host_timeout = q.tout;

endmodule

// File: rtl/smi_tunnel_sva.sv
module smi_tunnel_sva #(
    parameter logic [4:0] SW_ADDR    = 5'h10,
    parameter logic [4:0] CMD_REG    = 5'h00,
    parameter logic [4:0] STATUS_REG = 5'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_valid,
    input logic        host_ready,
    input logic        host_rw,
    input logic [4:0]  host_phy,
    input logic [4:0]  host_reg,
    input logic        host_done,
    input logic [15:0] host_rdata,
    input logic        host_timeout,
    input logic        mdio_req,
    input logic        mdio_rw,
    input logic [4:0]  mdio_addr,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata,
    input logic        mdio_ack
);
    logic       lat_rw;
    logic [4:0] lat_phy;
    logic [4:0] lat_reg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_rw  <= 1'b0;
            lat_phy <= '0;
            lat_reg <= '0;
        end else if (host_valid && host_ready) begin
            lat_rw  <= host_rw;
            lat_phy <= host_phy;
            lat_reg <= host_reg;
        end
    end

    assert_bus_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |-> mdio_addr == SW_ADDR);

    assert_cmd_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_rw && mdio_reg == CMD_REG) |->
            (mdio_wdata[15] && mdio_wdata[12] &&
             $countones(mdio_wdata[11:10]) == 1 &&
             mdio_wdata[11] == !lat_rw &&
             mdio_wdata[9:5] == lat_phy && mdio_wdata[4:0] == lat_reg));

    assert_read_tout_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_done && host_timeout && !lat_rw) |-> host_rdata == 16'h0000);

    assert_status_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_rw && host_reg == STATUS_REG) |=>
            (host_done && !mdio_req));

    assert_status_other_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_rw && host_reg == STATUS_REG &&
         host_phy != SW_ADDR) |=> host_rdata == 16'h0000);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    assert_one_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |-> !host_ready);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=>
            (mdio_req && $stable(mdio_rw) && $stable(mdio_reg) && $stable(mdio_wdata)));

endmodule

bind smi_tunnel_seq smi_tunnel_sva #(
    .SW_ADDR    (SW_ADDR),
    .CMD_REG    (CMD_REG),
    .STATUS_REG (STATUS_REG)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_valid   (host_valid),
    .host_ready   (host_ready),
    .host_rw      (host_rw),
    .host_phy     (host_phy),
    .host_reg     (host_reg),
    .host_done    (host_done),
    .host_rdata   (host_rdata),
    .host_timeout (host_timeout),
    .mdio_req     (mdio_req),
    .mdio_rw      (mdio_rw),
    .mdio_addr    (mdio_addr),
    .mdio_reg     (mdio_reg),
    .mdio_wdata   (mdio_wdata),
    .mdio_ack     (mdio_ack)
);

// File: tb/smi_tunnel_seq_tb.sv
`timescale 1ns/1ps
module smi_tunnel_seq_tb;

    localparam int K_POLL = 0, K_CMD = 1, K_DWR = 2, K_DRD = 3;
    localparam int NVEC = 8;

    // {rw, phy, reg, wdata, pre_busy, post_busy}
    localparam logic [34:0] VECS [0:NVEC-1] = '{
        {1'b0, 5'd3,  5'd2,  16'h0000, 4'd0, 4'd2},
        {1'b1, 5'd7,  5'd4,  16'hA5C3, 4'd1, 4'd0},
        {1'b0, 5'd16, 5'd1,  16'h0000, 4'd0, 4'd0},
        {1'b0, 5'd5,  5'd1,  16'h0000, 4'd0, 4'd0},
        {1'b0, 5'd31, 5'd31, 16'h0000, 4'd3, 4'd1},
        {1'b1, 5'd16, 5'd1,  16'h1234, 4'd0, 4'd3},
        {1'b0, 5'd0,  5'd0,  16'h0000, 4'd0, 4'd0},
        {1'b1, 5'd31, 5'd0,  16'hFFFF, 4'd2, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_rw = 1'b0;
    logic [4:0]  host_phy = '0;
    logic [4:0]  host_reg = '0;
    logic [15:0] host_wdata = '0;
    logic        host_done;
    logic [15:0] host_rdata;
    logic        host_timeout;
    logic        mdio_req;
    logic        mdio_rw;
    logic [4:0]  mdio_addr;
    logic [4:0]  mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = '0;

    always #4 clk = ~clk;

    smi_tunnel_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_rw(host_rw),
        .host_phy(host_phy), .host_reg(host_reg), .host_wdata(host_wdata),
        .host_done(host_done), .host_rdata(host_rdata), .host_timeout(host_timeout),
        .mdio_req(mdio_req), .mdio_rw(mdio_rw), .mdio_addr(mdio_addr),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // bus model state
    logic [15:0] m_cmd = '0, m_dat = '0, m_last_cmd = '0;
    int          m_busy_rem = 0, m_post_busy = 0, m_acc = 0, m_bad_addr = 0;
    bit          m_stuck = 0;
    int          m_trace [64];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // downstream master model: answers one access per request
    initial begin
        forever begin
            @(negedge clk);
            if (mdio_req && !mdio_ack) begin
                int kind;
                if (mdio_addr != 5'h10) m_bad_addr++;
                if (!mdio_rw) begin
                    if (mdio_reg == 5'd0) begin
                        kind = K_POLL;
                        if (m_stuck || m_busy_rem > 0) begin
                            mdio_rdata = m_cmd | 16'h8000;
                            if (!m_stuck) m_busy_rem--;
                        end else begin
                            mdio_rdata = m_cmd & 16'h7FFF;
                        end
                    end else begin
                        kind = K_DRD;
                        mdio_rdata = m_dat;
                    end
                end else begin
                    if (mdio_reg == 5'd0) begin
                        kind = K_CMD;
                        m_cmd = mdio_wdata;
                        m_last_cmd = mdio_wdata;
                        m_busy_rem = m_post_busy;
                        if (mdio_wdata[11]) m_dat = {mdio_wdata[9:5], mdio_wdata[4:0], 6'h2D};
                    end else begin
                        kind = K_DWR;
                        m_dat = mdio_wdata;
                    end
                end
                if (m_acc < 64) m_trace[m_acc] = kind;
                m_acc++;
                mdio_ack = 1'b1;
            end else begin
                mdio_ack = 1'b0;
            end
        end
    end

    logic [15:0] r_data;
    logic        r_tout;
    logic        r_mid_ready;
    logic        r_done_after;

    task automatic run_req(input logic rw, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input int pre, input int post);
        @(negedge clk);
        m_acc       = 0;
        m_busy_rem  = pre;
        m_post_busy = post;
        host_rw     = rw;
        host_phy    = phy;
        host_reg    = rg;
        host_wdata  = wd;
        host_valid  = 1'b1;
        @(negedge clk);
        host_valid  = 1'b0;
        r_mid_ready = host_ready;
        while (!host_done) @(negedge clk);
        r_data = host_rdata;
        r_tout = host_timeout;
        @(negedge clk);
        r_done_after = host_done;
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 ready in reset", host_ready, 1);
        check("R11 done in reset", host_done, 0);
        check("R11 req in reset", mdio_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready after reset", host_ready, 1);
        check("R11 req after reset", mdio_req, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic        v_rw;
            logic [4:0]  v_phy, v_reg;
            logic [15:0] v_wd;
            int          v_pre, v_post, exp_acc;
            logic [15:0] exp_cmd;
            v_rw   = VECS[i][34];
            v_phy  = VECS[i][33:29];
            v_reg  = VECS[i][28:24];
            v_wd   = VECS[i][23:8];
            v_pre  = int'(VECS[i][7:4]);
            v_post = int'(VECS[i][3:0]);
            run_req(v_rw, v_phy, v_reg, v_wd, v_pre, v_post);
            check("R10 done one cycle", r_done_after, 0);
            check("R6 no timeout", r_tout, 0);
            if (!v_rw && v_reg == 5'd1) begin
                check("R8/R9 status value", r_data, (v_phy == 5'd16) ? 16'h0124 : 16'h0000);
                check("R8/R9 no bus access", m_acc, 0);
            end else begin
                exp_cmd = 16'h9000 | (v_rw ? 16'h0400 : 16'h0800) |
                          {6'b0, v_phy, v_reg};
                check("R10 busy while running", r_mid_ready, 0);
                check("R2 command word", m_last_cmd, exp_cmd);
                if (!v_rw) begin
                    exp_acc = (v_pre + 1) + 1 + (v_post + 1) + 1;
                    check("R5 access count read", m_acc, exp_acc);
                    check("R3 cmd after first wait", m_trace[v_pre + 1], K_CMD);
                    check("R3 data read last", m_trace[exp_acc - 1], K_DRD);
                    check("R3 read value", r_data, {v_phy, v_reg, 6'h2D});
                end else begin
                    exp_acc = (v_pre + 1) + 2 + (v_post + 1);
                    check("R4 access count write", m_acc, exp_acc);
                    check("R4 data write first", m_trace[v_pre + 1], K_DWR);
                    check("R4 cmd after data", m_trace[v_pre + 2], K_CMD);
                    check("R4 data reg value", m_dat, v_wd);
                    check("R4 write rdata zero", r_data, 0);
                end
            end
        end

        // stuck busy on a read: abort after the limit
        m_stuck = 1;
        run_req(1'b0, 5'd2, 5'd3, 16'h0, 0, 0);
        check("R6 read timeout flag", r_tout, 1);
        check("R6 read timeout data", r_data, 0);
        check("R6 read polls then stop", m_acc, 10000);
        check("R6 only polls", m_trace[63], K_POLL);

        // stuck busy on a write: sequence still completes
        run_req(1'b1, 5'd4, 5'd6, 16'h0BEE, 0, 0);
        check("R7 write timeout flag", r_tout, 1);
        check("R7 full write sequence", m_acc, 20002);
        check("R7 data still written", m_dat, 16'h0BEE);
        check("R7 command still issued", m_last_cmd, 16'h9400 | {6'b0, 5'd4, 5'd6});
        m_stuck = 0;

        // recovery after a timeout
        run_req(1'b0, 5'd9, 5'd12, 16'h0, 0, 1);
        check("R6 recovered no timeout", r_tout, 0);
        check("R3 recovered read value", r_data, {5'd9, 5'd12, 6'h2D});
        check("R1 all accesses at 0x10", m_bad_addr, 0);

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule